// File: doc/BRIEF.md
# Speculative Atomic Object Read Engine

This block sits at the destination side of a network interface and serves one-sided reads of whole objects. An object is a contiguous run of cache lines that starts at a line address (`req_base`) and spans `req_count` lines. The first line holds the object's version header. The engine does not wait for that header. It sends every line read of the object to the memory hierarchy straight away, in line order but without waiting on any answer. It gathers the answers, in whatever order they come back, into a per-request stream buffer.

While a read is in flight, the engine compares each coherence invalidation caused by a local write against the live address range of every active request. A hit means the object may be torn. The request then answers with a single abort beat, without waiting for the outstanding memory answers. Those answers are still taken in later and thrown away before the stream buffer is released. A request that finishes without a hit streams its lines back in address order.

Several requests run at once, one per stream buffer. A new request is held off while every buffer is occupied. Memory answers carry the identifier of their read, so they can return in any order.

Top module: `objrd_engine`

## Requirements
- R1: After reset `req_ready` is 1, and `mrd_valid` and `rsp_valid` are 0.
- R2: An accepted request produces exactly `req_count` memory reads, one for each address from `req_base` to `req_base+req_count-1`. All of them are issued before any memory answer for that request is returned.
- R3: A request with no conflict returns `req_count` beats carrying its `rsp_tag` with `rsp_abort`=0. Beat i carries the memory data of address `req_base+i`. `rsp_last` is 1 only on the final beat. A beat is held stable while `rsp_ready` is 0.
- R4: An invalidation whose address lies in `[req_base, req_base+req_count)`, seen while the request still has lines outstanding, turns the reply into one beat with `rsp_abort`=1 and `rsp_last`=1.
- R5: Invalidations at `req_base-1` and at `req_base+req_count` do not affect the reply.
- R6: An in-range invalidation in the same cycle as the request's final memory answer causes an abort.
- R7: Up to NSLOT requests are in flight at once. `req_ready` is 0 while all NSLOT are busy.
- R8: The abort beat is sent without waiting for the memory answers still outstanding for that request.
- R9: After an abort, late memory answers for that request are absorbed and produce no reply beats. The buffer is then freed, and later requests return correct data.
- R10: Concurrent requests whose memory answers return out of order each receive their own correct payload. The beats of different replies are never interleaved.
- R11: Each memory answer must echo the `mrd_id` of its read, which is {buffer index, line index}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Object read request present |
| req_ready | output | 1 | A stream buffer is free |
| req_tag | input | TAG_W | Requester tag, echoed in the reply |
| req_base | input | ADDR_W | Line address of the object's first line |
| req_count | input | CNT_W | Number of lines, 1 to MAX_LINES |
| mrd_valid | output | 1 | Line read to memory |
| mrd_ready | input | 1 | Memory accepts the read |
| mrd_addr | output | ADDR_W | Line address of the read |
| mrd_id | output | SLOT_W+LINE_W | Read identifier {buffer, line} |
| mrsp_valid | input | 1 | Memory answer present |
| mrsp_id | input | SLOT_W+LINE_W | Identifier of the answered read |
| mrsp_data | input | DATA_W | Line data |
| inv_valid | input | 1 | Invalidation from a local write |
| inv_addr | input | ADDR_W | Invalidated line address |
| rsp_valid | output | 1 | Reply beat present |
| rsp_ready | input | 1 | Requester accepts the beat |
| rsp_tag | output | TAG_W | Tag of the request |
| rsp_abort | output | 1 | Abort reply |
| rsp_last | output | 1 | Final beat of the reply |
| rsp_data | output | DATA_W | Payload line (0 on abort) |

## Verification
Single requests are swept over every line count and several bases, some with a stalling requester. This separates address generation and beat ordering from flow control. An invalidation is placed on each line of a held read, and the memory answers are kept back, which separates early abort from abort after completion. The same held read with invalidations one line below and one line above the range checks the range bounds. An invalidation timed onto the final memory answer isolates the same-cycle case. Four concurrent reads with scattered memory latencies show the buffers filling up, answers being routed by identifier, and replies not being interleaved.

// File: rtl/objrd_pkg.sv
`timescale 1ns/1ps
package objrd_pkg;

   // per-line stream buffer entry state
   typedef enum logic [1:0] {
      LN_FREE = 2'd0,   // not issued
      LN_USED = 2'd1,   // read issued, answer pending
      LN_DONE = 2'd2    // answer captured
   } line_st_e;

   // per-request buffer state
   typedef enum logic [2:0] {
      SL_IDLE  = 3'd0,
      SL_RUN   = 3'd1,   // issuing and collecting, range watched
      SL_SEND  = 3'd2,   // streaming payload
      SL_ABORT = 3'd3,   // abort beat offered
      SL_DRAIN = 3'd4    // absorbing late answers after abort
   } slot_st_e;

endpackage

// File: rtl/objrd_arb.sv
`timescale 1ns/1ps
module objrd_arb #(
   parameter int N           = 4,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] gnt
);
   localparam int PW = $clog2(N);

   logic [PW-1:0] ptr_q;
   logic [PW-1:0] win;
   int            idx;

   // search starts one past the last winner; a fixed pointer gives lowest-first
   always_comb begin
      gnt = '0;
      win = '0;
      idx = 0;
      for (int k = 0; k < N; k++) begin
         idx = (int'(ptr_q) + 1 + k) % N;
         if (gnt == '0 && req[idx]) begin
            gnt[idx] = 1'b1;
            win      = PW'(idx);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ptr_q <= PW'(N - 1);
      else if (adv && ROUND_ROBIN && |req) ptr_q <= win;
   end

   assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_grant_when_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|(gnt & req)));

endmodule

// File: rtl/objrd_slot.sv
`timescale 1ns/1ps
module objrd_slot
   import objrd_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 4,
   parameter int MAX_LINES = 8,
   parameter int LINE_W    = 3,
   parameter int CNT_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   // allocation
   input  logic              alloc,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic [ADDR_W-1:0] alloc_base,
   input  logic [CNT_W-1:0]  alloc_cnt,
   output logic              busy,
   // line reads
   output logic              iss_req,
   output logic [LINE_W-1:0] iss_line,
   output logic [ADDR_W-1:0] iss_addr,
   input  logic              iss_take,
   // memory answers routed to this buffer
   input  logic              ret_valid,
   input  logic [LINE_W-1:0] ret_line,
   input  logic [DATA_W-1:0] ret_data,
   // invalidations
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   // reply beats
   output logic              out_req,
   output logic              out_abort,
   output logic              out_last,
   output logic [TAG_W-1:0]  out_tag,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_take
);

   slot_st_e          st_q, st_d;
   line_st_e          ent_q [MAX_LINES];
   logic [DATA_W-1:0] buf_q [MAX_LINES];
   logic [TAG_W-1:0]  tag_q;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  iss_ptr_q;
   logic [CNT_W-1:0]  snd_ptr_q;

   logic              hit;
   logic [ADDR_W:0]   off;
   logic              all_done;
   logic              any_used;
   logic              go_idle;

   // range match: offset from base, negative when below base
   assign off = {1'b0, inv_addr} - {1'b0, base_q};
   assign hit = inv_valid && !off[ADDR_W] && (off[ADDR_W-1:0] < ADDR_W'(cnt_q));

   always_comb begin
      all_done = 1'b1;
      any_used = 1'b0;
      for (int i = 0; i < MAX_LINES; i++) begin
         if (CNT_W'(i) < cnt_q && ent_q[i] != LN_DONE) all_done = 1'b0;
         if (ent_q[i] == LN_USED)                       any_used = 1'b1;
      end
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         SL_IDLE:  if (alloc) st_d = SL_RUN;
         SL_RUN: begin
            if (hit)           st_d = SL_ABORT;
            else if (all_done) st_d = SL_SEND;
         end
         SL_SEND:  if (out_take && out_last) st_d = SL_IDLE;
         SL_ABORT: if (out_take) st_d = any_used ? SL_DRAIN : SL_IDLE;
         SL_DRAIN: if (!any_used) st_d = SL_IDLE;
         default:  st_d = SL_IDLE;
      endcase
   end

   assign go_idle = (st_q != SL_IDLE) && (st_d == SL_IDLE);
   assign busy    = (st_q != SL_IDLE);

   // issue: every line back to back, version line not awaited
   assign iss_req  = (st_q == SL_RUN) && (iss_ptr_q < cnt_q) && !hit;
   assign iss_line = iss_ptr_q[LINE_W-1:0];
   assign iss_addr = base_q + ADDR_W'(iss_ptr_q);

   assign out_req   = (st_q == SL_SEND) || (st_q == SL_ABORT);
   assign out_abort = (st_q == SL_ABORT);
   assign out_last  = out_abort || (snd_ptr_q == cnt_q - CNT_W'(1));
   assign out_tag   = tag_q;
   assign out_data  = out_abort ? '0 : buf_q[snd_ptr_q[LINE_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SL_IDLE;
         tag_q     <= '0;
         base_q    <= '0;
         cnt_q     <= '0;
         iss_ptr_q <= '0;
         snd_ptr_q <= '0;
      end else begin
         st_q <= st_d;
         if (alloc) begin
            tag_q     <= alloc_tag;
            base_q    <= alloc_base;
            cnt_q     <= alloc_cnt;
            iss_ptr_q <= '0;
            snd_ptr_q <= '0;
         end else begin
            if (iss_req && iss_take)             iss_ptr_q <= iss_ptr_q + CNT_W'(1);
            if (out_take && st_q == SL_SEND)     snd_ptr_q <= snd_ptr_q + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MAX_LINES; i++) ent_q[i] <= LN_FREE;
      end else begin
         for (int i = 0; i < MAX_LINES; i++) begin
            if (go_idle)
               ent_q[i] <= LN_FREE;
            else if (iss_req && iss_take && iss_line == LINE_W'(i))
               ent_q[i] <= LN_USED;
            else if (ret_valid && ret_line == LINE_W'(i))
               ent_q[i] <= LN_DONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < MAX_LINES; i++)
         if (ret_valid && ret_line == LINE_W'(i)) buf_q[i] <= ret_data;
   end

   // a line is read at most once per request
   assert_issue_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_req |-> (ent_q[iss_line] == LN_FREE));
   // answers only arrive for outstanding reads
   assert_answer_matches_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> (busy && ent_q[ret_line] == LN_USED));
   // payload is streamed only when every line has been captured
   assert_send_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SL_SEND) |-> all_done);
   // a range hit while running leads to the abort beat
   assert_hit_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SL_RUN && hit) |=> (st_q == SL_ABORT));
   // buffer released only after late answers are absorbed
   assert_free_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(!any_used));
   // allocation only into an idle buffer
   assert_alloc_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (st_q == SL_IDLE));

endmodule

// File: rtl/objrd_engine.sv
`timescale 1ns/1ps
module objrd_engine #(
   parameter int NSLOT     = 4,
   parameter int MAX_LINES = 8,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 4,
   parameter bit ISSUE_RR  = 1'b1,
   localparam int SLOT_W   = $clog2(NSLOT),
   localparam int LINE_W   = $clog2(MAX_LINES),
   localparam int CNT_W    = $clog2(MAX_LINES + 1),
   localparam int ID_W     = SLOT_W + LINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [CNT_W-1:0]  req_count,
   output logic              mrd_valid,
   input  logic              mrd_ready,
   output logic [ADDR_W-1:0] mrd_addr,
   output logic [ID_W-1:0]   mrd_id,
   input  logic              mrsp_valid,
   input  logic [ID_W-1:0]   mrsp_id,
   input  logic [DATA_W-1:0] mrsp_data,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic              rsp_abort,
   output logic              rsp_last,
   output logic [DATA_W-1:0] rsp_data
);

   // elaboration-time parameter checks
   if (NSLOT < 2)             begin : g_bad_nslot $error("NSLOT must be at least 2"); end
   if (MAX_LINES < 2)         begin : g_bad_lines $error("MAX_LINES must be at least 2"); end
   if (ADDR_W <= CNT_W)       begin : g_bad_addr  $error("ADDR_W must exceed CNT_W"); end
   if ((1 << LINE_W) != MAX_LINES) begin : g_bad_pow2 $error("MAX_LINES must be a power of two"); end

   logic [NSLOT-1:0]  s_busy, s_alloc, s_iss_req, s_iss_take, s_ret;
   logic [NSLOT-1:0]  s_out_req, s_out_abort, s_out_last, s_out_take;
   logic [LINE_W-1:0] s_iss_line [NSLOT];
   logic [ADDR_W-1:0] s_iss_addr [NSLOT];
   logic [TAG_W-1:0]  s_out_tag  [NSLOT];
   logic [DATA_W-1:0] s_out_data [NSLOT];

   logic [NSLOT-1:0]  free_pick;
   logic [NSLOT-1:0]  iss_gnt;
   logic [NSLOT-1:0]  arb_rsp_gnt, rsp_gnt;
   logic [NSLOT-1:0]  own_q;
   logic              own_v_q;

   // intake: lowest free buffer
   always_comb begin
      free_pick = '0;
      for (int s = 0; s < NSLOT; s++)
         if (free_pick == '0 && !s_busy[s]) free_pick[s] = 1'b1;
   end
   assign req_ready = |free_pick;
   assign s_alloc   = (req_valid && req_ready) ? free_pick : '0;

   // per-request stream buffers
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign s_ret[s] = mrsp_valid && (mrsp_id[ID_W-1:LINE_W] == SLOT_W'(s));
      objrd_slot #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
         .MAX_LINES(MAX_LINES), .LINE_W(LINE_W), .CNT_W(CNT_W)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (s_alloc[s]),
         .alloc_tag (req_tag),
         .alloc_base(req_base),
         .alloc_cnt (req_count),
         .busy      (s_busy[s]),
         .iss_req   (s_iss_req[s]),
         .iss_line  (s_iss_line[s]),
         .iss_addr  (s_iss_addr[s]),
         .iss_take  (s_iss_take[s]),
         .ret_valid (s_ret[s]),
         .ret_line  (mrsp_id[LINE_W-1:0]),
         .ret_data  (mrsp_data),
         .inv_valid (inv_valid),
         .inv_addr  (inv_addr),
         .out_req   (s_out_req[s]),
         .out_abort (s_out_abort[s]),
         .out_last  (s_out_last[s]),
         .out_tag   (s_out_tag[s]),
         .out_data  (s_out_data[s]),
         .out_take  (s_out_take[s])
      );
   end

   // memory read issue: one line per cycle across buffers
   objrd_arb #(.N(NSLOT), .ROUND_ROBIN(ISSUE_RR)) u_iss_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (s_iss_req),
      .adv  (mrd_valid && mrd_ready),
      .gnt  (iss_gnt)
   );

   assign mrd_valid  = |s_iss_req;
   assign s_iss_take = mrd_ready ? iss_gnt : '0;

   always_comb begin
      mrd_addr = '0;
      mrd_id   = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (iss_gnt[s]) begin
            mrd_addr = s_iss_addr[s];
            mrd_id   = {SLOT_W'(s), s_iss_line[s]};
         end
      end
   end

   // reply port: lowest index first, owner locked until final beat leaves
   objrd_arb #(.N(NSLOT), .ROUND_ROBIN(1'b0)) u_rsp_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (s_out_req),
      .adv  (1'b0),
      .gnt  (arb_rsp_gnt)
   );

   assign rsp_gnt    = own_v_q ? own_q : arb_rsp_gnt;
   assign rsp_valid  = |(rsp_gnt & s_out_req);
   assign s_out_take = rsp_ready ? (rsp_gnt & s_out_req) : '0;

   always_comb begin
      rsp_tag   = '0;
      rsp_abort = 1'b0;
      rsp_last  = 1'b0;
      rsp_data  = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (rsp_gnt[s] && s_out_req[s]) begin
            rsp_tag   = s_out_tag[s];
            rsp_abort = s_out_abort[s];
            rsp_last  = s_out_last[s];
            rsp_data  = s_out_data[s];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_v_q <= 1'b0;
         own_q   <= '0;
      end else begin
         own_v_q <= rsp_valid && !(rsp_ready && rsp_last);
         own_q   <= rsp_gnt;
      end
   end

   // stalled beat stays put
   assert_rsp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_tag) && $stable(rsp_data) && $stable(rsp_abort) && $stable(rsp_last)));
   // one reply stream at a time
   assert_one_stream_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_gnt & s_out_req));
   // a started reply is not preempted before its last beat
   assert_no_interleave_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready && !rsp_last) |=> (rsp_valid && $stable(rsp_tag)));
   // no intake when every buffer is busy
   assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (&s_busy) |-> !req_ready);

endmodule

// File: tb/objrd_engine_test.sv
`timescale 1ns/1ps
module objrd_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_tag = '0;
   logic [15:0] req_base = '0;
   logic [3:0]  req_count = '0;
   logic        mrd_valid;
   logic        mrd_ready = 1'b1;
   logic [15:0] mrd_addr;
   logic [4:0]  mrd_id;
   logic        mrsp_valid;
   logic [4:0]  mrsp_id;
   logic [31:0] mrsp_data;
   logic        inv_valid = 1'b0;
   logic [15:0] inv_addr = '0;
   logic        rsp_valid;
   logic        rsp_ready;
   logic [3:0]  rsp_tag;
   logic        rsp_abort;
   logic        rsp_last;
   logic [31:0] rsp_data;

   always #2.5 clk = ~clk;

   objrd_engine uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
      .req_base(req_base), .req_count(req_count),
      .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr), .mrd_id(mrd_id),
      .mrsp_valid(mrsp_valid), .mrsp_id(mrsp_id), .mrsp_data(mrsp_data),
      .inv_valid(inv_valid), .inv_addr(inv_addr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
      .rsp_abort(rsp_abort), .rsp_last(rsp_last), .rsp_data(rsp_data)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   function automatic logic [31:0] mem_word(input logic [15:0] a);
      return {a, ~a} ^ 32'h1234_5678;
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   bit          hold = 1'b0;     // 1: answers only on explicit release
   bit          rel_req = 1'b0;
   bit          rsp_stall = 1'b0;
   bit          p_v   [32];
   logic [4:0]  p_id  [32];
   logic [15:0] p_addr[32];
   int          p_tmr [32];
   int          issued_cnt = 0;
   int          issued_sum = 0;
   int          cyc = 0;

   function automatic int pending();
      int n = 0;
      for (int i = 0; i < 32; i++) if (p_v[i]) n++;
      return n;
   endfunction

   initial begin
      bit stored;
      mrsp_valid = 1'b0; mrsp_id = '0; mrsp_data = '0; rsp_ready = 1'b1;
      for (int i = 0; i < 32; i++) p_v[i] = 1'b0;
      forever begin
         @(posedge clk); #1;
         mrsp_valid = 1'b0;
         if (rst_n) begin
            if (!hold || rel_req) begin
               for (int i = 0; i < 32; i++) begin
                  if (!mrsp_valid && p_v[i] && (hold || p_tmr[i] == 0)) begin
                     mrsp_valid = 1'b1;
                     mrsp_id    = p_id[i];
                     mrsp_data  = mem_word(p_addr[i]);
                     p_v[i]     = 1'b0;
                  end
               end
               rel_req = 1'b0;
            end
            for (int i = 0; i < 32; i++) if (p_v[i] && p_tmr[i] > 0) p_tmr[i]--;
            if (mrd_valid && mrd_ready) begin
               stored = 1'b0;
               for (int i = 0; i < 32; i++) begin
                  if (!stored && !p_v[i]) begin
                     p_v[i] = 1'b1; p_id[i] = mrd_id; p_addr[i] = mrd_addr;
                     p_tmr[i] = 2 + (int'(mrd_addr) * 5) % 7;
                     stored = 1'b1;
                  end
               end
               issued_cnt++;
               issued_sum += int'(mrd_addr);
            end
            cyc++;
            rsp_ready = rsp_stall ? (cyc % 3 != 0) : 1'b1;
         end
      end
   end

   // ---------------- reply collector ----------------
   logic [31:0] bdat [16][8];
   int          bcnt [16];
   int          extra[16];
   bit          got_abort[16];
   bit          got_done [16];
   bit          open_v = 1'b0;
   int          open_t = 0;
   int          inter = 0;
   int          ct;

   always @(negedge clk) begin
      if (rst_n && rsp_valid && rsp_ready) begin
         ct = int'(rsp_tag);
         if (got_done[ct]) extra[ct]++;
         if (open_v && open_t != ct) inter++;
         if (rsp_abort) got_abort[ct] = 1'b1;
         else begin
            if (bcnt[ct] < 8) bdat[ct][bcnt[ct]] = rsp_data;
            bcnt[ct]++;
         end
         if (rsp_last) begin got_done[ct] = 1'b1; open_v = 1'b0; end
         else begin open_v = 1'b1; open_t = ct; end
      end
   end

   task automatic clear_tag(input int t);
      bcnt[t] = 0; extra[t] = 0; got_abort[t] = 1'b0; got_done[t] = 1'b0;
   endtask

   task automatic send_req(input logic [3:0] t, input logic [15:0] b, input int n);
      clear_tag(int'(t));
      req_valid = 1'b1; req_tag = t; req_base = b; req_count = 4'(n);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input int t);
      for (int i = 0; i < 300 && !got_done[t]; i++) @(negedge clk);
   endtask

   task automatic release_n(input int n);
      repeat (n) begin rel_req = 1'b1; @(negedge clk); end
   endtask

   task automatic check_data(input int t, input logic [15:0] b, input int n, input string rq);
      chk(got_done[t], rq, "reply completed", got_done[t], 1);
      chk(!got_abort[t], rq, "abort flag", got_abort[t], 0);
      chk(bcnt[t] == n, rq, "beat count", bcnt[t], n);
      chk(extra[t] == 0, rq, "beats after last", extra[t], 0);
      for (int i = 0; i < n && i < 8; i++)
         chk(bdat[t][i] == mem_word(b + 16'(i)), rq, "payload beat",
             bdat[t][i], mem_word(b + 16'(i)));
   endtask

   task automatic check_abort(input int t, input string rq);
      chk(got_done[t], rq, "abort reply seen", got_done[t], 1);
      chk(got_abort[t], rq, "abort flag", got_abort[t], 1);
      chk(bcnt[t] == 0, rq, "payload beats on abort", bcnt[t], 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [15:0] bases [3];
      int          t;
      bases[0] = 16'h0040; bases[1] = 16'h1233; bases[2] = 16'hFFF0;
      for (int i = 0; i < 16; i++) clear_tag(i);

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
      chk(mrd_valid == 1'b0, "R1", "mrd_valid in reset", mrd_valid, 0);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && !mrd_valid && !rsp_valid, "R1", "idle after reset",
          {req_ready, mrd_valid, rsp_valid}, 3'b100);

      // R2 / R3: sweep counts and bases, some with requester stalls
      for (int n = 1; n <= 8; n++) begin
         for (int bi = 0; bi < 3; bi++) begin
            t = (n * 3 + bi) % 16;
            rsp_stall = (n % 2 == 0);
            issued_cnt = 0; issued_sum = 0;
            send_req(4'(t), bases[bi], n);
            wait_done(t);
            check_data(t, bases[bi], n, "R3");
            chk(issued_cnt == n, "R2", "read count", issued_cnt, n);
            chk(issued_sum == n * int'(bases[bi]) + n * (n - 1) / 2, "R2", "read address sum",
                issued_sum, n * int'(bases[bi]) + n * (n - 1) / 2);
         end
      end
      rsp_stall = 1'b0;

      // R2: all reads out before any answer (answers held)
      hold = 1'b1; issued_cnt = 0;
      send_req(4'd5, 16'h0200, 8);
      repeat (14) @(negedge clk);
      chk(issued_cnt == 8, "R2", "reads issued with no answer back", issued_cnt, 8);
      release_n(8);
      wait_done(5);
      check_data(5, 16'h0200, 8, "R2");

      // R4 / R8: invalidation on each line of a held read
      for (int k = 0; k < 6; k++) begin
         send_req(4'd6, 16'h0300, 6);
         repeat (10) @(negedge clk);
         release_n(2);
         inv_valid = 1'b1; inv_addr = 16'h0300 + 16'(k);
         @(negedge clk);
         inv_valid = 1'b0;
         wait_done(6);
         check_abort(6, "R4");
         chk(pending() == 4, "R8", "answers outstanding at abort", pending(), 4);
         release_n(4);
         repeat (4) @(negedge clk);
         chk(bcnt[6] == 0 && extra[6] == 0, "R9", "no beats from late answers",
             bcnt[6] + extra[6], 0);
      end

      // R9: buffers reusable after drains
      hold = 1'b0;
      send_req(4'd7, 16'h0310, 7);
      wait_done(7);
      check_data(7, 16'h0310, 7, "R9");
      chk(req_ready == 1'b1, "R9", "buffers free after drain", req_ready, 1);

      // R5: invalidation just below and just above the range
      hold = 1'b1;
      for (int side = 0; side < 2; side++) begin
         send_req(4'd8, 16'h0400, 6);
         repeat (10) @(negedge clk);
         inv_valid = 1'b1; inv_addr = (side == 0) ? 16'h03FF : 16'h0406;
         @(negedge clk);
         inv_valid = 1'b0;
         release_n(6);
         wait_done(8);
         check_data(8, 16'h0400, 6, "R5");
      end

      // R6: invalidation in the cycle of the final answer
      send_req(4'd9, 16'h0500, 3);
      repeat (8) @(negedge clk);
      release_n(2);
      rel_req = 1'b1;
      @(negedge clk);
      inv_valid = 1'b1; inv_addr = 16'h0502;
      @(negedge clk);
      inv_valid = 1'b0;
      wait_done(9);
      check_abort(9, "R6");
      hold = 1'b0;
      repeat (6) @(negedge clk);

      // R7 / R10: four concurrent reads, scattered latencies, stalling requester
      rsp_stall = 1'b1; inter = 0;
      send_req(4'd1, 16'h0800, 8);
      send_req(4'd2, 16'h0903, 5);
      send_req(4'd3, 16'h0A07, 3);
      send_req(4'd4, 16'h0B01, 7);
      chk(req_ready == 1'b0, "R7", "req_ready with all buffers busy", req_ready, 0);
      wait_done(1); wait_done(2); wait_done(3); wait_done(4);
      check_data(1, 16'h0800, 8, "R10");
      check_data(2, 16'h0903, 5, "R10");
      check_data(3, 16'h0A07, 3, "R10");
      check_data(4, 16'h0B01, 7, "R10");
      chk(inter == 0, "R10", "interleaved reply beats", inter, 0);
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R7", "req_ready after buffers free", req_ready, 1);
      rsp_stall = 1'b0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule